// File: doc/BRIEF.md
# Cell Bus Frame Receiver and Checker

This block watches a shared 32-bit cell bus whose traffic is cut into fixed frames of sixteen clock cycles. A frame-sync input marks the first cycle of a frame. From then on a phase counter free-runs through the frame. Each cycle has one role: the opening cycle carries one request bit per attached device, the next fourteen carry one cell, and the closing cycle carries a column-parity word for that cell together with the grant for the following frame.

The receiver copies the request vector out once per frame. It stores the fourteen cell words and splits them into routing header, tandem header, VPI, VCI, PTI, CLP and 48 payload bytes. It XORs the cell words together and compares the result with the parity carried in the closing cycle, then decodes and checks the grant field.

A cell is only taken when the previous frame ended with a valid grant, since otherwise no device is driving the cell section. The accepted cell is shown for one cycle with its parity-error flag. A frame-sync pulse that arrives off its expected cycle realigns the counter and drops whatever was half collected.

Top module: `cellbus_rx`

## Requirements
- R1: Until the first frame_sync pulse the block is idle: req_stb, grant_stb and cell_valid stay low whatever bus_data carries.
- R2: The cycle in which frame_sync is high, or in which the free-running count returns to zero, is frame cycle 0. bus_data[15:0] of that cycle appears on req_vec, with req_stb high for exactly the next cycle.
- R3: In frame cycle 15 the grant field is bus_data[3:0] (number), bus_data[4] (enable) and bus_data[5] (check bit). In the next cycle grant_stb is high for one cycle and grant_num shows the number. grant_valid is high only when the enable is 1 and the six bits [5:0] hold an odd number of ones.
- R4: The cell of a frame is collected and delivered only if the frame before it ended with grant_valid high. Otherwise no cell_valid follows that frame.
- R5: A delivered cell raises cell_valid for exactly one cycle, the cycle after frame cycle 15. Word 1 gives cell_route = [31:16] and cell_tandem = [15:0]. Word 2 gives cell_vpi = [31:20], cell_vci = [19:4], cell_pti = [3:1] and cell_clp = [0]. Payload byte i is taken from word 3+i/4, bits [31-8*(i%4) -: 8], and is shown at cell_payload[8*i +: 8].
- R6: Let X be the XOR of the words in frame cycles 1 to 14. cell_par_err is high together with cell_valid exactly when X[31:16]^X[15:0] differs from bus_data[31:16] of frame cycle 15.
- R7: A frame_sync pulse that arrives while locked and at a nonzero count restarts the frame at cycle 0. It drops the partly collected cell and clears the pending grant, so the frame that starts there delivers no cell.
- R8: Once locked, frames repeat every 16 cycles without further sync pulses. A sync pulse at the expected cycle 0 leaves the framing and the cell flow unchanged.
- R9: A grant whose enable is 0, or whose check bit gives an even count of ones, leaves grant_valid low and stops the next frame's cell from being delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High in frame cycle 0 |
| bus_data | input | 32 | Shared cell bus word |
| req_vec | output | 16 | Request bits captured in cycle 0 |
| req_stb | output | 1 | One-cycle pulse when req_vec is updated |
| grant_num | output | 4 | Decoded grant number |
| grant_valid | output | 1 | Grant passed its enable and check bit |
| grant_stb | output | 1 | One-cycle pulse when the grant outputs are updated |
| cell_valid | output | 1 | One-cycle strobe for a delivered cell |
| cell_par_err | output | 1 | Column-parity mismatch for the delivered cell |
| cell_route | output | 16 | Routing header |
| cell_tandem | output | 16 | Tandem routing header |
| cell_vpi | output | 12 | VPI (with GFC bits) |
| cell_vci | output | 16 | VCI |
| cell_pti | output | 3 | Payload type |
| cell_clp | output | 1 | Cell loss priority |
| cell_payload | output | 384 | 48 payload bytes, byte i at [8*i +: 8] |

## Verification
Each cell is built from a different seed, so every field and every payload byte must come from the correct word and lane. A parity word that is correct and one with a single flipped bit show whether the fold and the compare agree. Grants are tried with the enable low, with a bad check bit and correctly formed, and each is followed by a frame that must or must not yield a cell, which tells arming apart from decoding. Framing is tested with no further sync, with a sync in the expected cycle, and with one that cuts a frame after six cycles, so that a true realign can be told apart from a harmless one.

// File: rtl/cellbus_rx_pkg.sv
package cellbus_rx_pkg;
    localparam int BUS_W      = 32;
    localparam int FRAME_LEN  = 16;
    localparam int CELL_WORDS = 14;
    localparam int REQ_W      = 16;
    localparam int DEV_N      = 16;
    localparam int GNUM_W     = $clog2(DEV_N);
    localparam int PH_W       = $clog2(FRAME_LEN);
    localparam int PAR_W      = BUS_W / 2;
    localparam int HDR_WORDS  = 2;
    localparam int PAY_BYTES  = (CELL_WORDS - HDR_WORDS) * (BUS_W / 8);

    // fold a full-width column parity into the half-width field carried on the bus
    function automatic logic [PAR_W-1:0] fold_par(input logic [BUS_W-1:0] w);
        return w[BUS_W-1:PAR_W] ^ w[PAR_W-1:0];
    endfunction
endpackage

// File: rtl/cellbus_rx_frame.sv
module cellbus_rx_frame #(
    parameter int FRAME_LEN = cellbus_rx_pkg::FRAME_LEN,
    parameter int REQ_W     = cellbus_rx_pkg::REQ_W,
    localparam int PH_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic [REQ_W-1:0] req_in,
    output logic [PH_W-1:0]  phase,
    output logic             active,
    output logic             resync,
    output logic [REQ_W-1:0] req_vec,
    output logic             req_stb
);
    localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic             locked;
        logic [PH_W-1:0]  cnt;
        logic [REQ_W-1:0] req;
        logic             req_stb;
    } frame_st_t;

    frame_st_t q, d;
    logic [PH_W-1:0] cur;

    always_comb begin
        cur    = frame_sync ? '0 : q.cnt;
        active = q.locked | frame_sync;
        resync = frame_sync & q.locked & (q.cnt != '0);
        d         = q;
        d.req_stb = 1'b0;
        if (active) begin
            d.locked = 1'b1;
            d.cnt    = (cur == LAST) ? '0 : cur + 1'b1;
            if (cur == '0) begin
                d.req     = req_in;
                d.req_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phase   = cur;
    assign req_vec = q.req;
    assign req_stb = q.req_stb;

    // R1: nothing counts or strobes before the first sync
    a_r1_idle_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !q.locked |-> (q.cnt == '0 && !q.req_stb));
endmodule

// File: rtl/cellbus_rx_grant.sv
module cellbus_rx_grant #(
    parameter int GNUM_W = cellbus_rx_pkg::GNUM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last,
    input  logic              resync,
    input  logic [GNUM_W+1:0] gfield,
    output logic [GNUM_W-1:0] grant_num,
    output logic              grant_valid,
    output logic              grant_stb,
    output logic              arm
);
    typedef struct packed {
        logic              armed;
        logic [GNUM_W-1:0] num;
        logic              valid;
        logic              stb;
    } grant_st_t;

    grant_st_t q, d;
    logic      en_bit;
    logic      ok;

    always_comb begin
        en_bit = gfield[GNUM_W];
        ok     = en_bit & (^gfield);
        d      = q;
        d.stb  = 1'b0;
        if (resync) d.armed = 1'b0;
        if (last) begin
            d.num   = gfield[GNUM_W-1:0];
            d.valid = ok;
            d.armed = ok;
            d.stb   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign grant_num   = q.num;
    assign grant_valid = q.valid;
    assign grant_stb   = q.stb;
    assign arm         = q.armed & ~resync;

    // R3: the valid flag only moves with its strobe
    a_r3_valid_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !q.stb |-> $stable(q.valid));
    // R9: a pending grant always comes from a valid decode
    a_r9_arm_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed |-> q.valid);
    // R7: a realign drops the pending grant
    a_r7_resync_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !q.armed);
endmodule

// File: rtl/cellbus_rx_cell.sv
module cellbus_rx_cell #(
    parameter int BUS_W      = cellbus_rx_pkg::BUS_W,
    parameter int CELL_WORDS = cellbus_rx_pkg::CELL_WORDS,
    parameter int FRAME_LEN  = cellbus_rx_pkg::FRAME_LEN,
    localparam int PH_W      = $clog2(FRAME_LEN),
    localparam int PAR_W     = BUS_W / 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [PH_W-1:0]                      phase,
    input  logic                                 active,
    input  logic                                 arm,
    input  logic [BUS_W-1:0]                     bus_data,
    output logic [CELL_WORDS-1:0][BUS_W-1:0]     cell_words,
    output logic                                 cell_valid,
    output logic                                 par_err
);
    localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic                             collect;
        logic [CELL_WORDS-1:0][BUS_W-1:0] words;
        logic [BUS_W-1:0]                 acc;
        logic                             valid;
        logic                             err;
    } cell_st_t;

    cell_st_t q, d;
    int       idx;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.err   = 1'b0;
        idx     = int'(phase) - 1;
        if (active) begin
            if (phase == '0) begin
                d.collect = arm;
                d.acc     = '0;
            end else if (phase <= PH_W'(CELL_WORDS)) begin
                if (q.collect) begin
                    d.words[idx] = bus_data;
                    d.acc        = q.acc ^ bus_data;
                end
            end else if (phase == LAST) begin
                if (q.collect) begin
                    d.valid = 1'b1;
                    d.err   = cellbus_rx_pkg::fold_par(q.acc) != bus_data[BUS_W-1:PAR_W];
                end
                d.collect = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cell_words = q.words;
    assign cell_valid = q.valid;
    assign par_err    = q.err;

    // R5: delivery strobe lasts a single cycle
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);
    // R6: the error flag never stands without a cell
    a_r6_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> q.valid);
    // R4: a cell only follows a frame that was being collected
    a_r4_valid_from_collect: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(q.collect));
endmodule

// File: rtl/cellbus_rx.sv
module cellbus_rx #(
    parameter int BUS_W      = cellbus_rx_pkg::BUS_W,
    parameter int FRAME_LEN  = cellbus_rx_pkg::FRAME_LEN,
    parameter int CELL_WORDS = cellbus_rx_pkg::CELL_WORDS,
    parameter int REQ_W      = cellbus_rx_pkg::REQ_W,
    parameter int GNUM_W     = cellbus_rx_pkg::GNUM_W,
    localparam int PAY_BYTES = (CELL_WORDS - 2) * (BUS_W / 8),
    localparam int LANES     = BUS_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_sync,
    input  logic [BUS_W-1:0]       bus_data,
    output logic [REQ_W-1:0]       req_vec,
    output logic                   req_stb,
    output logic [GNUM_W-1:0]      grant_num,
    output logic                   grant_valid,
    output logic                   grant_stb,
    output logic                   cell_valid,
    output logic                   cell_par_err,
    output logic [15:0]            cell_route,
    output logic [15:0]            cell_tandem,
    output logic [11:0]            cell_vpi,
    output logic [15:0]            cell_vci,
    output logic [2:0]             cell_pti,
    output logic                   cell_clp,
    output logic [8*PAY_BYTES-1:0] cell_payload
);
    localparam int PH_W = $clog2(FRAME_LEN);
    localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_LEN - 1);

    logic [PH_W-1:0]                  phase;
    logic                             active;
    logic                             resync;
    logic                             arm;
    logic [CELL_WORDS-1:0][BUS_W-1:0] words;

    cellbus_rx_frame #(.FRAME_LEN(FRAME_LEN), .REQ_W(REQ_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .req_in     (bus_data[REQ_W-1:0]),
        .phase      (phase),
        .active     (active),
        .resync     (resync),
        .req_vec    (req_vec),
        .req_stb    (req_stb)
    );

    cellbus_rx_grant #(.GNUM_W(GNUM_W)) u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .last        (active && phase == LAST),
        .resync      (resync),
        .gfield      (bus_data[GNUM_W+1:0]),
        .grant_num   (grant_num),
        .grant_valid (grant_valid),
        .grant_stb   (grant_stb),
        .arm         (arm)
    );

    cellbus_rx_cell #(.BUS_W(BUS_W), .CELL_WORDS(CELL_WORDS), .FRAME_LEN(FRAME_LEN)) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .active     (active),
        .arm        (arm),
        .bus_data   (bus_data),
        .cell_words (words),
        .cell_valid (cell_valid),
        .par_err    (cell_par_err)
    );

    // header words: word 0 = routing/tandem, word 1 = ATM header
    assign cell_route  = words[0][31:16];
    assign cell_tandem = words[0][15:0];
    assign cell_vpi    = words[1][31:20];
    assign cell_vci    = words[1][19:4];
    assign cell_pti    = words[1][3:1];
    assign cell_clp    = words[1][0];

    for (genvar i = 0; i < PAY_BYTES; i++) begin : g_pay
        assign cell_payload[8*i +: 8] = words[2 + i / LANES][BUS_W-1-8*(i % LANES) -: 8];
    end
endmodule

// File: tb/cellbus_rx_test.sv
module cellbus_rx_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_sync = 1'b0;
    logic [31:0]  bus_data = '0;
    logic [15:0]  req_vec;
    logic         req_stb;
    logic [3:0]   grant_num;
    logic         grant_valid, grant_stb;
    logic         cell_valid, cell_par_err;
    logic [15:0]  cell_route, cell_tandem, cell_vci;
    logic [11:0]  cell_vpi;
    logic [2:0]   cell_pti;
    logic         cell_clp;
    logic [383:0] cell_payload;

    cellbus_rx uut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bus_data(bus_data),
        .req_vec(req_vec), .req_stb(req_stb),
        .grant_num(grant_num), .grant_valid(grant_valid), .grant_stb(grant_stb),
        .cell_valid(cell_valid), .cell_par_err(cell_par_err),
        .cell_route(cell_route), .cell_tandem(cell_tandem), .cell_vpi(cell_vpi),
        .cell_vci(cell_vci), .cell_pti(cell_pti), .cell_clp(cell_clp),
        .cell_payload(cell_payload)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int n_req = 0, n_cell = 0, n_gnt = 0;
    logic [15:0]  m_req;
    logic         m_err, m_gv, m_clp;
    logic [3:0]   m_gn;
    logic [15:0]  m_route, m_tandem, m_vci;
    logic [11:0]  m_vpi;
    logic [2:0]   m_pti;
    logic [383:0] m_pay;

    // monitor samples well after each rising edge
    always @(posedge clk) begin
        #2;
        if (req_stb) begin n_req++; m_req = req_vec; end
        if (grant_stb) begin n_gnt++; m_gv = grant_valid; m_gn = grant_num; end
        if (cell_valid) begin
            n_cell++; m_err = cell_par_err; m_route = cell_route; m_tandem = cell_tandem;
            m_vpi = cell_vpi; m_vci = cell_vci; m_pti = cell_pti; m_clp = cell_clp; m_pay = cell_payload;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] seed, input int c);
        return (seed + 32'(c) * 32'h01030507) ^ {8'(c), 24'h5A3C00};
    endfunction

    task automatic run_frame(input bit sync, input logic [15:0] req, input logic [31:0] seed,
                             input bit ge, input bit gp_bad, input logic [3:0] num,
                             input bit par_bad, input int len);
        logic [31:0] acc;
        logic        gp;
        acc = '0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            frame_sync = (c == 0) && sync;
            if (c == 0) bus_data = {16'hDEAD, req};
            else if (c <= 14) begin
                bus_data = word_of(seed, c);
                acc ^= bus_data;
            end else begin
                gp = ~(^{ge, num}) ^ gp_bad;
                bus_data = {(acc[31:16] ^ acc[15:0]) ^ {15'd0, par_bad}, 10'd0, gp, ge, num};
            end
        end
        @(posedge clk);
        #3;
    endtask

    task automatic check_cell(input string tag, input logic [31:0] seed);
        logic [31:0] w1, w2, w;
        int bad;
        w1 = word_of(seed, 1);
        w2 = word_of(seed, 2);
        check({tag, " R5 route"},  m_route,  w1[31:16]);
        check({tag, " R5 tandem"}, m_tandem, w1[15:0]);
        check({tag, " R5 vpi"},    m_vpi,    w2[31:20]);
        check({tag, " R5 vci"},    m_vci,    w2[19:4]);
        check({tag, " R5 pti"},    m_pti,    w2[3:1]);
        check({tag, " R5 clp"},    m_clp,    w2[0]);
        bad = 0;
        for (int i = 0; i < 48; i++) begin
            w = word_of(seed, 3 + i / 4);
            if (m_pay[8*i +: 8] !== w[31-8*(i%4) -: 8]) bad++;
        end
        check({tag, " R5 payload bytes wrong"}, bad, 0);
    endtask

    task automatic t_reset_idle();
        check("R1 req_stb at reset", req_stb, 0);
        check("R1 cell_valid at reset", cell_valid, 0);
        check("R1 grant_valid at reset", grant_valid, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bus_data = 32'h0000_0035 ^ (32'(i) << 8);
        end
        @(posedge clk); #3;
        check("R1 no strobes before sync", n_req + n_cell + n_gnt, 0);
    endtask

    task automatic t_first_frame();
        run_frame(1, 16'hA5C3, 32'h1111_0000, 1, 0, 4'd7, 0, 16);
        check("R2 req count", n_req, 1);
        check("R2 req value", m_req, 16'hA5C3);
        check("R4 no cell without prior grant", n_cell, 0);
        check("R3 grant strobe", n_gnt, 1);
        check("R3 grant valid", m_gv, 1);
        check("R3 grant number", m_gn, 7);
    endtask

    task automatic t_cell_good_par();
        run_frame(0, 16'h0001, 32'hC0DE_1234, 1, 1, 4'd3, 0, 16);
        check("R8 R4 cell delivered free-running", n_cell, 1);
        check("R2 req second frame", m_req, 16'h0001);
        check("R6 no parity error", m_err, 0);
        check_cell("cell A", 32'hC0DE_1234);
        check("R9 bad check bit gives invalid", m_gv, 0);
        check("R3 number kept", m_gn, 3);
    endtask

    task automatic t_unarmed();
        run_frame(0, 16'h8000, 32'h0BAD_0BAD, 0, 0, 4'd9, 0, 16);
        check("R9 R4 no cell after bad check bit", n_cell, 1);
        check("R9 enable low gives invalid", m_gv, 0);
        run_frame(0, 16'h4000, 32'h2222_3333, 1, 0, 4'd12, 0, 16);
        check("R9 R4 no cell after disabled grant", n_cell, 1);
        check("R3 grant valid again", m_gv, 1);
        check("R3 grant number 12", m_gn, 12);
    endtask

    task automatic t_par_err();
        run_frame(0, 16'h00FF, 32'h7E57_AB01, 1, 0, 4'd15, 1, 16);
        check("R4 cell after valid grant", n_cell, 2);
        check("R6 parity error flagged", m_err, 1);
        check_cell("cell B", 32'h7E57_AB01);
    endtask

    task automatic t_aligned_sync();
        run_frame(1, 16'h0F0F, 32'h3141_5926, 1, 0, 4'd0, 0, 16);
        check("R8 aligned sync keeps cell", n_cell, 3);
        check("R8 R6 no error after aligned sync", m_err, 0);
        check_cell("cell C", 32'h3141_5926);
    endtask

    task automatic t_resync();
        int c0;
        c0 = n_cell;
        run_frame(0, 16'h1234, 32'hDEAD_0001, 1, 0, 4'd1, 0, 6);
        run_frame(1, 16'h4321, 32'hBEEF_0002, 1, 0, 4'd2, 0, 16);
        check("R7 no cell from cut or realigned frame", n_cell, c0);
        check("R7 R2 req from realigned frame", m_req, 16'h4321);
        check("R7 grant decoded after realign", m_gn, 2);
        run_frame(0, 16'h5555, 32'hFACE_0003, 0, 0, 4'd0, 0, 16);
        check("R7 cell resumes after realign", n_cell, c0 + 1);
        check_cell("cell D", 32'hFACE_0003);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #3;
        t_reset_idle();
        t_first_frame();
        t_cell_good_par();
        t_unarmed();
        t_par_err();
        t_aligned_sync();
        t_resync();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule